// File: doc/BRIEF.md
# Framed Word Serializer with Sync Burst

This block converts a 10-bit parallel word into a framed serial bitstream, one word per word-clock period. The bit-rate clock and the lock indication come from an external clock multiplier. The word clock is sampled in the bit-clock domain. A static edge-select input decides which word-clock transition captures the word. Every word goes out as a 12-bit frame: a leading 1, the ten data bits least significant first, and a trailing 0. The receiver uses the guaranteed 1-to-0 boundary between frames to find the word alignment.

Two sync request inputs are OR-combined and filtered over word captures. Once a request has been seen at six consecutive captures, the block replaces payload with a burst of 1024 sync frames. A receiver can use that burst to acquire the bit clock. A request still held when a burst ends starts another burst at once.

The serial output enable models the tri-state control of a line driver. It is high only while lock is present and power-down is released. While it is low the serial data output is held at 0.

Top module: `ser_framed_tx`

## Requirements
- R1: Each captured word is sent as a 12-bit frame on serial_out. The frame is a 1, then data_in bits 0 to 9 in that order, then a 0, one bit per clk cycle. The first bit appears in the cycle after the clk edge that sees the capturing word-clock transition.
- R2: With edge_sel=1 a low-to-high transition of word_clk captures a word. With edge_sel=0 a high-to-low transition captures a word. The opposite transition has no effect on the frame in flight.
- R3: sync_a and sync_b are OR-combined, so either one alone can start a burst.
- R4: A sync frame replaces data only at a capture where the combined request is high and was also high at each of the five preceding captures. A shorter run, or a run broken by one low capture, leaves all frames as data.
- R5: A sync frame is six 1s followed by six 0s in send order. An accepted request yields exactly 1024 consecutive sync frames, starting with the accepting capture. Dropping the request during a burst does not shorten it.
- R6: If the combined request is still high at the capture after a burst's last frame, a new 1024-frame burst starts with that capture.
- R7: serial_oe is high in the cycle after pll_lock=1 and pwrdn=0 are sampled. It is low in the cycle after pll_lock=0 or pwrdn=1 is sampled. serial_out is 0 whenever serial_oe is low.
- R8: During reset and after it, serial_oe and serial_out are 0 and no burst is pending. The first burst after reset needs the full six-capture filtered request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Word clock, sampled on clk |
| edge_sel | input | 1 | Static capture edge select: 1 rising, 0 falling |
| data_in | input | 10 | Parallel payload word |
| sync_a | input | 1 | Sync request, first source |
| sync_b | input | 1 | Sync request, second source |
| pll_lock | input | 1 | Clock multiplier locked |
| pwrdn | input | 1 | Power-down, active high |
| serial_out | output | 1 | Serial frame bit |
| serial_oe | output | 1 | Serial output enable (tri-state control) |

## Verification
The bench drives the capturing word-clock transition at a falling clk edge, so the design sees it at the following rising edge. It then samples the 12 frame bits on the next 12 falling clk edges, bit k at the (k+1)-th one. Each capture pushes an expected frame, computed from a model of the filter and burst rules, into a queue. A monitor pops that frame and compares it bit by bit over that window. Changes on lock and power-down are checked on serial_oe and serial_out at the first falling edge after one rising edge, because the enable is a single register.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int DEF_DATA_W    = 10;
  localparam int DEF_FILT_LEN  = 6;
  localparam int DEF_BURST_LEN = 1024;

  typedef enum logic {FK_DATA = 1'b0, FK_SYNC = 1'b1} frame_kind_e;
endpackage

// File: rtl/ser_edge_detect.sv
module ser_edge_detect (
  input  logic clk,
  input  logic rst_ns,
  input  logic word_clk,
  input  logic edge_sel,
  output logic strobe
);
  logic wclk_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) wclk_q <= 1'b0;
    else         wclk_q <= word_clk;
  end

  always_comb begin
    if (edge_sel) strobe = word_clk & ~wclk_q;
    else          strobe = ~word_clk & wclk_q;
  end
endmodule

// File: rtl/ser_sync_ctrl.sv
module ser_sync_ctrl
  import ser_pkg::*;
#(
  parameter int FILT_LEN  = DEF_FILT_LEN,
  parameter int BURST_LEN = DEF_BURST_LEN
) (
  input  logic        clk,
  input  logic        rst_ns,
  input  logic        strobe,
  input  logic        req,
  output frame_kind_e kind
);
  localparam int FILT_W  = $clog2(FILT_LEN);
  localparam int BURST_W = $clog2(BURST_LEN);
  localparam logic [FILT_W-1:0]  FILT_TOP  = FILT_W'(FILT_LEN - 1);
  localparam logic [BURST_W-1:0] BURST_TOP = BURST_W'(BURST_LEN - 1);

  logic [FILT_W-1:0]  filt_q, filt_d;
  logic [BURST_W-1:0] burst_q, burst_d;

  always_comb begin
    filt_d  = filt_q;
    burst_d = burst_q;
    kind    = FK_DATA;
    if (strobe) begin
      if (!req)                 filt_d = '0;
      else if (filt_q != FILT_TOP) filt_d = filt_q + 1'b1;
      if (burst_q != '0) begin
        kind    = FK_SYNC;
        burst_d = burst_q - 1'b1;
      end else if (req && (filt_q == FILT_TOP)) begin
        kind    = FK_SYNC;
        burst_d = BURST_TOP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      filt_q  <= '0;
      burst_q <= '0;
    end else if (strobe) begin
      filt_q  <= filt_d;
      burst_q <= burst_d;
    end
  end

  // R4: no idle request and no burst pending means payload goes out
  a_r4_no_sync_without_req: assert property (@(posedge clk) disable iff (!rst_ns)
    (strobe && !req && burst_q == '0) |-> (kind == FK_DATA));

  // R5: a burst started from idle leaves BURST_LEN-1 frames to go
  a_r5_burst_start: assert property (@(posedge clk) disable iff (!rst_ns)
    (strobe && burst_q == '0 && kind == FK_SYNC) |=> (burst_q == BURST_TOP));
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int FRAME_W = ser_pkg::DEF_DATA_W + 2
) (
  input  logic               clk,
  input  logic               rst_ns,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               bit_out
);
  logic [FRAME_W-1:0] sh_q, sh_d;

  always_comb begin
    if (load) sh_d = frame;
    else      sh_d = {1'b0, sh_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign bit_out = sh_q[0];

  // R1: the bit at frame position 0 is the first one sent
  a_r1_first_bit: assert property (@(posedge clk) disable iff (!rst_ns)
    load |=> (bit_out == $past(frame[0])));
endmodule

// File: rtl/ser_framed_tx.sv
module ser_framed_tx
  import ser_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int FILT_LEN  = DEF_FILT_LEN,
  parameter int BURST_LEN = DEF_BURST_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_clk,
  input  logic              edge_sel,
  input  logic [DATA_W-1:0] data_in,
  input  logic              sync_a,
  input  logic              sync_b,
  input  logic              pll_lock,
  input  logic              pwrdn,
  output logic              serial_out,
  output logic              serial_oe
);
  localparam int FRAME_W = DATA_W + 2;

  logic [1:0]         rst_pipe;
  logic               rst_ns;
  logic               strobe;
  frame_kind_e        kind;
  logic [FRAME_W-1:0] sync_word, load_word;
  logic               sh_bit;
  logic               oe_q, oe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  ser_edge_detect u_edge (
    .clk(clk), .rst_ns(rst_ns), .word_clk(word_clk),
    .edge_sel(edge_sel), .strobe(strobe)
  );

  ser_sync_ctrl #(.FILT_LEN(FILT_LEN), .BURST_LEN(BURST_LEN)) u_sync (
    .clk(clk), .rst_ns(rst_ns), .strobe(strobe),
    .req(sync_a | sync_b), .kind(kind)
  );

  always_comb begin
    for (int i = 0; i < FRAME_W; i++) sync_word[i] = (i < FRAME_W / 2);
    if (kind == FK_SYNC) load_word = sync_word;
    else                 load_word = {1'b0, data_in, 1'b1};
  end

  ser_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_ns(rst_ns), .load(strobe),
    .frame(load_word), .bit_out(sh_bit)
  );

  assign oe_d = pll_lock & ~pwrdn;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) oe_q <= 1'b0;
    else         oe_q <= oe_d;
  end

  assign serial_oe  = oe_q;
  assign serial_out = sh_bit & oe_q;

  // R7: loss of lock disables the output one cycle later
  a_r7_lock_off: assert property (@(posedge clk) disable iff (!rst_ns)
    !pll_lock |=> !serial_oe);

  // R7: power-down disables the output one cycle later
  a_r7_pwrdn_off: assert property (@(posedge clk) disable iff (!rst_ns)
    pwrdn |=> !serial_oe);

  // R7: locked and powered means enabled next cycle
  a_r7_enable_on: assert property (@(posedge clk) disable iff (!rst_ns)
    (pll_lock && !pwrdn) |=> serial_oe);
endmodule

// File: tb/ser_framed_tx_tb_top.sv
`timescale 1ns/1ps
module ser_framed_tx_tb_top;
  typedef struct {
    logic [11:0] f;
    string       tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n, word_clk, edge_sel, sync_a, sync_b, pll_lock, pwrdn;
  logic [9:0] data_in;
  logic       serial_out, serial_oe;

  int   n_checks = 0;
  int   n_fail   = 0;
  exp_t exp_q[$];
  event frame_go;

  int    m_filt, m_burst;
  logic  m_prev_sync;
  string start_tag, data_tag;

  always #2 clk = ~clk;

  ser_framed_tx dut_i (
    .clk(clk), .rst_n(rst_n), .word_clk(word_clk), .edge_sel(edge_sel),
    .data_in(data_in), .sync_a(sync_a), .sync_b(sync_b),
    .pll_lock(pll_lock), .pwrdn(pwrdn),
    .serial_out(serial_out), .serial_oe(serial_oe)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_filt = 0; m_burst = 0; m_prev_sync = 1'b0;
  endtask

  task automatic send_word(input logic [9:0] d, input logic sa, input logic sb);
    exp_t e;
    logic req;
    @(negedge clk);
    data_in = d; sync_a = sa; sync_b = sb;
    word_clk = edge_sel;
    req = sa | sb;
    if (m_burst != 0) begin
      e.f = 12'h03F; e.tag = "R5"; m_burst--;
      m_prev_sync = 1'b1;
    end else if (req && m_filt >= 5) begin
      e.f = 12'h03F; e.tag = m_prev_sync ? "R6" : start_tag; m_burst = 1023;
      m_prev_sync = 1'b1;
    end else begin
      e.f = {1'b0, d, 1'b1}; e.tag = data_tag;
      m_prev_sync = 1'b0;
    end
    m_filt = req ? m_filt + 1 : 0;
    exp_q.push_back(e);
    #1 -> frame_go;
    repeat (6) @(negedge clk);
    word_clk = ~edge_sel;
    repeat (5) @(negedge clk);
  endtask

  initial begin : monitor
    logic [11:0] got;
    exp_t e;
    forever begin
      @(frame_go);
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        got[k] = serial_out;
      end
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(got == e.f, e.tag, got, e.f);
      end
    end
  end

  task automatic do_reset(input logic esel);
    @(negedge clk);
    rst_n = 1'b0; edge_sel = esel; word_clk = ~esel;
    sync_a = 1'b0; sync_b = 1'b0; data_in = '0;
    repeat (3) @(negedge clk);
    check(!serial_oe && !serial_out, "R8", {10'd0, serial_oe, serial_out}, 12'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  initial begin : main
    rst_n = 1'b0; pll_lock = 1'b0; pwrdn = 1'b0;
    start_tag = "R4"; data_tag = "R1";
    do_reset(1'b1);
    check(!serial_oe, "R7", {11'd0, serial_oe}, 12'd0);
    pll_lock = 1'b1;
    @(negedge clk);
    check(serial_oe, "R7", {11'd0, serial_oe}, 12'd1);
    pwrdn = 1'b1;
    @(negedge clk);
    check(!serial_oe && !serial_out, "R7", {10'd0, serial_oe, serial_out}, 12'd0);
    pwrdn = 1'b0;
    @(negedge clk);
    check(serial_oe, "R7", {11'd0, serial_oe}, 12'd1);
    pll_lock = 1'b0;
    @(negedge clk);
    check(!serial_oe, "R7", {11'd0, serial_oe}, 12'd0);
    pll_lock = 1'b1;
    @(negedge clk);

    // rising capture edge, payload patterns
    send_word(10'h155, 1'b0, 1'b0);
    send_word(10'h2AA, 1'b0, 1'b0);
    send_word(10'h3FF, 1'b0, 1'b0);
    send_word(10'h001, 1'b0, 1'b0);
    // R4: five captures then a drop, then three, a gap and five
    for (int i = 0; i < 5; i++) send_word(10'(i * 37), 1'b1, 1'b0);
    send_word(10'h200, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send_word(10'(i + 90), 1'b1, 1'b0);
    send_word(10'h0F0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) send_word(10'(i * 101), 1'b1, 1'b0);
    send_word(10'h00F, 1'b0, 1'b0);
    // R5: accepted on the sixth, dropped early, burst runs to 1024
    for (int i = 0; i < 8; i++) send_word(10'(i * 53), 1'b1, 1'b0);
    for (int i = 0; i < 1030; i++) send_word(10'(i * 13), 1'b0, 1'b0);

    // R2/R3: falling capture edge, second sync input held through two bursts
    start_tag = "R3"; data_tag = "R2";
    repeat (16) @(negedge clk);
    do_reset(1'b0);
    send_word(10'h123, 1'b0, 1'b0);
    send_word(10'h321, 1'b0, 1'b0);
    for (int i = 0; i < 1050; i++) send_word(10'(i * 7), 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) send_word(10'(i + 500), 1'b0, 1'b0);
    repeat (16) @(negedge clk);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : watchdog
    #700000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule